// File: doc/BRIEF.md
# Crystal Timebase Periodic Calibrator

This block turns a crystal-rate clock enable into timekeeping pulses. A divider counts qualified crystal ticks into a one-cycle seconds pulse and a half-second tick. A seconds counter groups those pulses into a one-cycle minute tick. Once per minute the block corrects the divider for oscillator drift. The correction comes from a signed calibration register, and each unit of that register is worth four crystal ticks.

A positive calibration value corrects a slow crystal. At the minute boundary the divider is preloaded with the extra ticks, so the first second of the new minute is shorter. A negative value corrects a fast crystal. The divider is frozen for that many ticks, so the first second of the new minute is longer. A value of zero leaves the timing unchanged.

The calibration register accepts a write only while the timer is stopped, or in the cycle in which the seconds pulse is high. A write at any other time is dropped and sets a sticky error flag. The flag stays set until it is cleared through a dedicated input.

Top module: `xtc_timebase`

## Requirements
- R1: Reset clears the divider, the seconds counter, the calibration value and the error flag, and drives every output low. The first seconds pulse after reset therefore comes exactly TICKS_PER_SEC qualified ticks later.
- R2: A qualified tick is a cycle with `run` and `tick_en` both high. `sec_pulse` is high for exactly one cycle, in the cycle after the qualified tick that completes a second. Uncorrected seconds are TICKS_PER_SEC qualified ticks apart.
- R3: `half_tick` is high in every cycle in which `sec_pulse` is high. Between two seconds pulses it is high for exactly one other cycle, after the divider steps past its midpoint value TICKS_PER_SEC/2-1. This holds for every second, including corrected ones, when TICKS_PER_SEC is at least 2^(CAL_W+2).
- R4: `min_tick` is high for one cycle, together with every SECS_PER_MIN-th seconds pulse counted from reset, and at no other time.
- R5: When the calibration value c is positive at a minute boundary, the first second of the new minute lasts TICKS_PER_SEC - 4*c qualified ticks.
- R6: When c is negative at a minute boundary, the first second of the new minute lasts TICKS_PER_SEC + 4*|c| qualified ticks.
- R7: When c is zero, every second, including the first of each minute, lasts TICKS_PER_SEC qualified ticks.
- R8: A write (`cal_wr` high) is accepted in either of two cases: `run` is low, or `sec_pulse` is high in that cycle. The register then holds `cal_val` from the next cycle on, and the write does not set `cal_err`.
- R9: A write in any other cycle leaves the calibration value unchanged and sets `cal_err` from the next cycle. `cal_err` then stays high until a cycle with `err_clr` high and no rejected write. A rejected write in the same cycle as `err_clr` keeps the flag set.
- R10: While `run` is low the divider and the seconds counter hold their state, and no `sec_pulse`, `half_tick` or `min_tick` is produced.
- R11: `cal_val` is an 8-bit two's-complement number (for the default CAL_W). The extreme value -128 (bit pattern 0x80) lengthens the first second of the minute by 512 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Crystal-rate clock enable, one cycle per crystal tick |
| run | input | 1 | Timer run control; low freezes the timebase |
| cal_wr | input | 1 | Calibration write strobe |
| cal_val | input | CAL_W | Signed calibration value to write |
| err_clr | input | 1 | Clears the sticky write-error flag |
| sec_pulse | output | 1 | One-cycle seconds pulse |
| half_tick | output | 1 | One-cycle tick every half second |
| min_tick | output | 1 | One-cycle minute tick, coincident with a seconds pulse |
| cal_err | output | 1 | Sticky flag: a calibration write was rejected |

## Verification
The properties depend on a few assumptions about the block and its inputs:
- TICKS_PER_SEC is greater than one, so that a seconds pulse cannot repeat on consecutive cycles.
- The scaled correction stays below half a second of ticks, so that the midpoint tick still occurs in a shortened second.
- A legal write relies only on the registered `sec_pulse` value seen in the same cycle as `cal_wr`.

The stimulus keeps within these assumptions in the following ways:
- It runs a 1024-tick second, so the extreme values 127 and -128 still leave the midpoint reachable.
- It issues legal writes only in a `sec_pulse` cycle or while stopped, and issues rejected writes only in cycles with `run` high and `sec_pulse` low.
- It changes every input half a clock away from the active edge.
- For part of the run it thins `tick_en` to two of every three cycles, so that second lengths are measured in qualified ticks rather than in cycles.

// File: rtl/xtc_pkg.sv
package xtc_pkg;

  // How the pending drift correction acts on the divider at a minute boundary.
  typedef enum logic [1:0] {
    CORR_NONE    = 2'd0,
    CORR_ADVANCE = 2'd1,
    CORR_HOLD    = 2'd2
  } corr_kind_e;

  // Each calibration unit is worth 2**CAL_SHIFT crystal ticks.
  localparam int CAL_SHIFT = 2;

endpackage

// File: rtl/xtc_cal_guard.sv
module xtc_cal_guard
  import xtc_pkg::*;
#(
  parameter int CAL_W = 8,
  parameter int MAG_W = CAL_W + 1 + CAL_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sec_pulse,
  input  logic             wr,
  input  logic [CAL_W-1:0] wr_val,
  input  logic             err_clr,
  output logic [CAL_W-1:0] cal_o,
  output corr_kind_e       corr_kind_o,
  output logic [MAG_W-1:0] corr_mag_o,
  output logic             err_o
);

  logic [CAL_W-1:0] cal_q;
  logic             err_q;
  logic             legal;
  logic             neg;
  logic [CAL_W:0]   ext;
  logic [CAL_W:0]   abs_val;

  // Writes are safe when stopped or right after a seconds boundary.
  assign legal = !run || sec_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr && legal) begin
        cal_q <= wr_val;
      end
      if (wr && !legal) begin
        err_q <= 1'b1;
      end else if (err_clr) begin
        err_q <= 1'b0;
      end
    end
  end

  // Magnitude of the two's-complement value, scaled to crystal ticks.
  assign neg     = cal_q[CAL_W-1];
  assign ext     = {cal_q[CAL_W-1], cal_q};
  assign abs_val = neg ? (~ext + (CAL_W+1)'(1)) : ext;

  always_comb begin
    corr_mag_o = {abs_val, {CAL_SHIFT{1'b0}}};
    if (cal_q == '0) begin
      corr_kind_o = CORR_NONE;
    end else if (neg) begin
      corr_kind_o = CORR_HOLD;
    end else begin
      corr_kind_o = CORR_ADVANCE;
    end
  end

  assign cal_o = cal_q;
  assign err_o = err_q;

endmodule

// File: rtl/xtc_divider.sv
module xtc_divider
  import xtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MAG_W         = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             last_sec,
  input  corr_kind_e       corr_kind,
  input  logic [MAG_W-1:0] corr_mag,
  output logic             wrap_o,
  output logic             sec_pulse_o,
  output logic             half_tick_o
);

  localparam int DIV_W = $clog2(TICKS_PER_SEC);
  localparam logic [DIV_W-1:0] LAST_CNT = DIV_W'(TICKS_PER_SEC - 1);
  localparam logic [DIV_W-1:0] MID_CNT  = DIV_W'(TICKS_PER_SEC / 2 - 1);

  logic [DIV_W-1:0] cnt_q;
  logic [MAG_W-1:0] hold_q;
  logic             holding;
  logic             adv;
  logic             sec_q;
  logic             half_q;

  assign holding = (hold_q != '0);
  assign adv     = step && !holding;
  assign wrap_o  = adv && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
      sec_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      sec_q  <= wrap_o;
      half_q <= adv && ((cnt_q == MID_CNT) || (cnt_q == LAST_CNT));
      if (step && holding) begin
        hold_q <= hold_q - MAG_W'(1);
      end
      if (wrap_o) begin
        cnt_q <= '0;
        if (last_sec) begin
          case (corr_kind)
            CORR_ADVANCE: cnt_q  <= DIV_W'(corr_mag);
            CORR_HOLD:    hold_q <= corr_mag;
            default:      ;
          endcase
        end
      end else if (adv) begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign sec_pulse_o = sec_q;
  assign half_tick_o = half_q;

endmodule

// File: rtl/xtc_sec_counter.sv
module xtc_sec_counter #(
  parameter int SECS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  output logic last_sec_o,
  output logic min_tick_o
);

  localparam int SEC_W = (SECS_PER_MIN > 2) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECS_PER_MIN - 1);

  logic [SEC_W-1:0] sec_q;
  logic             min_q;

  assign last_sec_o = (sec_q == LAST_SEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      min_q <= 1'b0;
    end else begin
      min_q <= wrap_i && last_sec_o;
      if (wrap_i) begin
        sec_q <= last_sec_o ? '0 : sec_q + SEC_W'(1);
      end
    end
  end

  assign min_tick_o = min_q;

endmodule

// File: rtl/xtc_timebase.sv
module xtc_timebase
  import xtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SECS_PER_MIN  = 60,
  parameter int CAL_W         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             run,
  input  logic             cal_wr,
  input  logic [CAL_W-1:0] cal_val,
  input  logic             err_clr,
  output logic             sec_pulse,
  output logic             half_tick,
  output logic             min_tick,
  output logic             cal_err
);

  localparam int MAG_W = CAL_W + 1 + CAL_SHIFT;

  logic             step;
  logic             wrap;
  logic             last_sec;
  logic [CAL_W-1:0] cal_q;
  corr_kind_e       corr_kind;
  logic [MAG_W-1:0] corr_mag;

  assign step = run && tick_en;

  xtc_cal_guard #(
    .CAL_W (CAL_W),
    .MAG_W (MAG_W)
  ) u_guard (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .sec_pulse   (sec_pulse),
    .wr          (cal_wr),
    .wr_val      (cal_val),
    .err_clr     (err_clr),
    .cal_o       (cal_q),
    .corr_kind_o (corr_kind),
    .corr_mag_o  (corr_mag),
    .err_o       (cal_err)
  );

  xtc_divider #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .MAG_W         (MAG_W)
  ) u_div (
    .clk         (clk),
    .rst         (rst),
    .step        (step),
    .last_sec    (last_sec),
    .corr_kind   (corr_kind),
    .corr_mag    (corr_mag),
    .wrap_o      (wrap),
    .sec_pulse_o (sec_pulse),
    .half_tick_o (half_tick)
  );

  xtc_sec_counter #(
    .SECS_PER_MIN (SECS_PER_MIN)
  ) u_sec (
    .clk        (clk),
    .rst        (rst),
    .wrap_i     (wrap),
    .last_sec_o (last_sec),
    .min_tick_o (min_tick)
  );

endmodule

// File: rtl/xtc_timebase_chk.sv
module xtc_timebase_chk #(
  parameter int CAL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             run,
  input logic             cal_wr,
  input logic [CAL_W-1:0] cal_val,
  input logic             err_clr,
  input logic             sec_pulse,
  input logic             half_tick,
  input logic             min_tick,
  input logic             cal_err,
  input logic [CAL_W-1:0] cal_q
);

  AST_SEC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> !sec_pulse); // R2

  AST_NO_TICK_NO_SEC: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> !sec_pulse); // R2

  AST_HALF_WITH_SEC: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> half_tick); // R3

  AST_MIN_WITH_SEC: assert property (@(posedge clk) disable iff (rst)
    min_tick |-> sec_pulse); // R4

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sec_pulse && !half_tick && !min_tick)); // R10

  AST_LEGAL_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (cal_wr && (!run || sec_pulse)) |=> (cal_q == $past(cal_val))); // R8

  AST_LEGAL_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (cal_wr && (!run || sec_pulse) && !cal_err) |=> !cal_err); // R8

  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (cal_wr && run && !sec_pulse) |=> cal_err); // R9

  AST_REJECT_KEEPS_CAL: assert property (@(posedge clk) disable iff (rst)
    (cal_wr && run && !sec_pulse) |=> $stable(cal_q)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cal_err && !err_clr) |=> cal_err); // R9

endmodule

bind xtc_timebase xtc_timebase_chk #(.CAL_W(CAL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .run       (run),
  .cal_wr    (cal_wr),
  .cal_val   (cal_val),
  .err_clr   (err_clr),
  .sec_pulse (sec_pulse),
  .half_tick (half_tick),
  .min_tick  (min_tick),
  .cal_err   (cal_err),
  .cal_q     (cal_q)
);

// File: tb/test_xtc_timebase.sv
module test_xtc_timebase;

  localparam int TPS = 1024;
  localparam int SPM = 4;
  localparam int CW  = 8;

  logic          clk     = 1'b0;
  logic          rst     = 1'b1;
  logic          tick_en = 1'b1;
  logic          run     = 1'b0;
  logic          cal_wr  = 1'b0;
  logic          err_clr = 1'b0;
  logic [CW-1:0] cal_val = '0;
  logic          sec_pulse, half_tick, min_tick, cal_err;

  always #10 clk = ~clk;

  xtc_timebase #(
    .TICKS_PER_SEC (TPS),
    .SECS_PER_MIN  (SPM),
    .CAL_W         (CW)
  ) i_xtc_timebase (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .run       (run),
    .cal_wr    (cal_wr),
    .cal_val   (cal_val),
    .err_clr   (err_clr),
    .sec_pulse (sec_pulse),
    .half_tick (half_tick),
    .min_tick  (min_tick),
    .cal_err   (cal_err)
  );

  int     n_chk = 0;
  int     n_fail = 0;
  int     exp_len_q[$];
  string  exp_tag_q[$];
  int     cal_model = 0;
  longint ticks = 0;
  longint last_ticks = 0;
  int     pulses = 0;
  int     mids = 0;
  int     cyc = 0;
  bit     en_pattern = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Count qualified ticks at the active edge; inputs only change at negedge.
  always @(posedge clk) begin
    cyc++;
    if (!rst && run && tick_en) ticks++;
  end

  always @(negedge clk) begin
    tick_en = en_pattern ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor: pops the expected second length and compares.
  always @(negedge clk) begin
    if (!rst) begin
      if (half_tick && !sec_pulse) mids++;
      if (min_tick && !sec_pulse) check(1'b0, "R4 min_tick without sec_pulse", 1, 0);
      if (sec_pulse) begin
        pulses++;
        if (exp_len_q.size() == 0) begin
          check(1'b0, "R2 scoreboard empty", 0, 1);
        end else begin
          int    e;
          string t;
          e = exp_len_q.pop_front();
          t = exp_tag_q.pop_front();
          check((ticks - last_ticks) == e, t, ticks - last_ticks, e);
        end
        check(mids == 1, "R3 midpoint half ticks per second", mids, 1);
        check(half_tick == 1'b1, "R3 half_tick with sec_pulse", half_tick, 1);
        check(min_tick == ((pulses % SPM) == 0), "R4 minute tick placement",
              min_tick, (pulses % SPM) == 0);
        mids = 0;
        last_ticks = ticks;
        // Predictor: push the expected length of the next second.
        if ((pulses % SPM) == 0) begin
          exp_len_q.push_back(TPS - 4 * cal_model);
          if (cal_model > 0)         exp_tag_q.push_back("R5 shortened first second");
          else if (cal_model == -128) exp_tag_q.push_back("R11 extreme negative value");
          else if (cal_model < 0)    exp_tag_q.push_back("R6 lengthened first second");
          else                       exp_tag_q.push_back("R7 zero correction");
        end else begin
          exp_len_q.push_back(TPS);
          exp_tag_q.push_back("R2 nominal second");
        end
      end
    end
  end

  task automatic wait_secs(input int n);
    int left;
    left = n;
    while (left > 0) begin
      @(negedge clk);
      if (sec_pulse) left--;
    end
  endtask

  task automatic write_legal(input int v);
    do @(negedge clk); while (!sec_pulse);
    cal_wr  = 1'b1;
    cal_val = v[CW-1:0];
    @(posedge clk);
    #1;
    cal_wr    = 1'b0;
    cal_model = v;
  endtask

  task automatic write_rejected(input int v, input bit with_clr);
    @(negedge clk);
    while (sec_pulse) @(negedge clk);
    cal_wr  = 1'b1;
    err_clr = with_clr;
    cal_val = v[CW-1:0];
    @(posedge clk);
    #1;
    cal_wr  = 1'b0;
    err_clr = 1'b0;
    @(negedge clk);
    check(cal_err == 1'b1, "R9 rejected write sets cal_err", cal_err, 1);
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1'b1;
    @(posedge clk);
    #1;
    err_clr = 1'b0;
    @(negedge clk);
    check(cal_err == 1'b0, "R9 err_clr clears flag", cal_err, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    exp_len_q.push_back(TPS);
    exp_tag_q.push_back("R1 first second after reset");
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sec_pulse == 1'b0, "R1 sec_pulse after reset", sec_pulse, 0);
    check(half_tick == 1'b0, "R1 half_tick after reset", half_tick, 0);
    check(min_tick == 1'b0, "R1 min_tick after reset", min_tick, 0);
    check(cal_err == 1'b0, "R1 cal_err after reset", cal_err, 0);
    run = 1'b1;
    wait_secs(SPM);

    write_legal(100);
    check(cal_err == 1'b0, "R8 legal write leaves cal_err low", cal_err, 0);
    wait_secs(2 * SPM);

    write_legal(-50);
    wait_secs(2 * SPM);

    // A rejected write must not replace -50: next minutes still predict -50.
    write_rejected(77, 1'b0);
    repeat (50) @(negedge clk);
    check(cal_err == 1'b1, "R9 cal_err sticky", cal_err, 1);
    clear_err();
    write_rejected(33, 1'b1);
    check(cal_err == 1'b1, "R9 reject beats err_clr", cal_err, 1);
    clear_err();
    wait_secs(SPM);

    begin
      int p0;
      @(negedge clk);
      run = 1'b0;
      p0 = pulses;
      @(negedge clk);
      cal_wr  = 1'b1;
      cal_val = 8'd127;
      @(posedge clk);
      #1;
      cal_wr    = 1'b0;
      cal_model = 127;
      @(negedge clk);
      check(cal_err == 1'b0, "R8 write while stopped accepted", cal_err, 0);
      repeat (300) @(negedge clk);
      check(pulses == p0, "R10 no pulses while stopped", pulses, p0);
      check(half_tick == 1'b0, "R10 no half_tick while stopped", half_tick, 0);
      run = 1'b1;
    end
    wait_secs(2 * SPM);

    en_pattern = 1'b1;
    write_legal(-128);
    wait_secs(2 * SPM);
    en_pattern = 1'b0;

    write_legal(0);
    wait_secs(2 * SPM);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R2 watchdog expired", 0, 1);
    finish_run();
  end

endmodule